// File: doc/BRIEF.md
# UART Transceiver with Selectable Line Routing

This block is an asynchronous serial transmitter and receiver pair sharing one baud timebase. Words to send enter on a parallel valid/ready port and leave as serial frames on the TxD output. Frames arriving on the receiver input are delivered as a one-cycle strobe with the word and a framing-error flag. Frames carry eight data bits, or nine when the long-frame control bit is set. The receiver oversamples its input at sixteen ticks per bit.

A small routing stage chooses where the receiver listens. In two-pin mode it listens to the RxD pin and the transmitter drives TxD. In internal loopback it listens to the transmitter's own output. In single-wire mode it listens to the TxD pin itself, and the transmitter drives that pin only while a frame is in flight. In both loop modes the RxD pin is ignored. The source-select bit only matters when loop enable is set.

Back-pressure applies only on the transmit side. The sender holds `tx_data` steady with `tx_valid` high until it sees `tx_ready` high at a clock edge, and a word is taken on each such edge. `tx_ready` stays low from the cycle after acceptance until the stop bit has been sent. The receive side has no ready signal: each `rx_valid` pulse must be captured in the cycle it appears. Control bits should only change while both directions are idle.

Top module: `uart_loop_xcvr`

## Requirements
- R1: After reset, `tx_ready` is 1, `rx_valid` and `rx_ferr` are 0, `txd_o` is 1 (idle high) and `txd_oe` is 1.
- R2: With `cfg_loop`=0 the receiver takes its input from `rxd_i` only, so frames the block sends on `txd_o` produce no `rx_valid`.
- R3: With `cfg_nine`=0 a sent frame on `txd_o` is a 0 start bit, then data bits 0..7 least-significant first, then a 1 stop bit, each bit lasting 16×`CLK_DIV` clock cycles. The line is 1 whenever `tx_ready` is 1.
- R4: With `cfg_nine`=1 both directions use frames of a start bit, data bits 0..7 least-significant first, data bit 8, then a stop bit.
- R5: A word is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 from the next cycle until that frame's stop bit has ended, and each accepted word produces exactly one frame.
- R6: The receiver starts a frame on a high-to-low input transition and keeps it only if the input is still low at the 8th of 16 samples. A low pulse shorter than half a bit yields no `rx_valid`.
- R7: Each received frame gives a `rx_valid` pulse lasting exactly one cycle, with `rx_data` holding the received bits. In 8-bit mode, `rx_data[8]` is 0.
- R8: `rx_ferr` is 1 only together with `rx_valid`, and only when the stop bit was sampled as 0. The data bits are still delivered.
- R9: With `cfg_loop`=1 and `cfg_src`=0 (internal loopback), every frame sent is received unchanged, whatever `rxd_i` is doing. `txd_oe` stays 1.
- R10: With `cfg_loop`=1 and `cfg_src`=1 (single-wire), the receiver listens to `txd_pin_i`, and `rxd_i` is ignored. `txd_oe` is 1 only while a frame is being sent (`tx_ready`=0) and 0 otherwise.
- R11: With `cfg_loop`=0, the value of `cfg_src` has no effect: `txd_oe` stays 1 and reception from `rxd_i` works unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_loop | input | 1 | 1 routes the receiver away from the RxD pin |
| cfg_src | input | 1 | With cfg_loop=1: 0 internal loopback, 1 single-wire |
| cfg_nine | input | 1 | 1 selects 9-bit data frames |
| tx_data | input | 9 | Word to send (bit 8 used only in 9-bit mode) |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmitter idle and able to take a word |
| rx_data | output | 9 | Last received word |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_ferr | output | 1 | Stop bit was 0 (valid with rx_valid) |
| txd_o | output | 1 | Transmit line level |
| txd_oe | output | 1 | Transmit line drive enable |
| txd_pin_i | input | 1 | Level read back from the TxD pin |
| rxd_i | input | 1 | Receive pin |

## Verification
The transmitter and receiver run at the same time. A frame can finish on the receive side in the very cycle the transmitter accepts a word or shifts a bit. The bench provokes this in two-pin mode by starting a frame on `rxd_i` at a random offset from a transmit handshake, and judges both directions against words it computes itself. In both loop modes the receiver's strobe for the echoed word arrives while the transmitter is still in its stop bit. So the bench checks that the echo arrives, and that the handshake still releases only after the stop bit.

// File: rtl/uart_lr_pkg.sv
package uart_lr_pkg;
  typedef enum logic [1:0] {
    RT_PINS = 2'd0,
    RT_LOOP = 2'd1,
    RT_WIRE = 2'd2
  } route_e;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  localparam int unsigned WORD_W = 9;
  localparam int unsigned FRAME_MAX = WORD_W + 2;

  function automatic route_e pick_route(input logic loop_en, input logic src_sel);
    if (!loop_en) return RT_PINS;
    return src_sel ? RT_WIRE : RT_LOOP;
  endfunction
endpackage

// File: rtl/uart_lr_baud.sv
module uart_lr_baud #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = $clog2(CLK_DIV + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(CLK_DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_lr_tx.sv
module uart_lr_tx
  import uart_lr_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              nine,
  input  logic [WORD_W-1:0] data,
  input  logic              valid,
  output logic              ready,
  output logic              line,
  output logic              busy
);
  localparam int unsigned CW = $clog2(OVS);
  localparam int unsigned BW = $clog2(FRAME_MAX + 1);

  logic [FRAME_MAX-1:0] shreg;
  logic [CW-1:0]        cnt;
  logic [BW-1:0]        bitn;
  logic [BW-1:0]        last_bit;
  logic                 active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '1;
      cnt      <= '0;
      bitn     <= '0;
      last_bit <= '0;
      active   <= 1'b0;
    end else if (!active) begin
      if (valid) begin
        if (nine) begin
          shreg    <= {1'b1, data[8], data[7:0], 1'b0};
          last_bit <= BW'(FRAME_MAX - 1);
        end else begin
          shreg    <= {2'b11, data[7:0], 1'b0};
          last_bit <= BW'(FRAME_MAX - 2);
        end
        cnt    <= '0;
        bitn   <= '0;
        active <= 1'b1;
      end
    end else if (tick) begin
      if (cnt == CW'(OVS - 1)) begin
        cnt   <= '0;
        shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
        bitn  <= bitn + 1'b1;
        if (bitn == last_bit) active <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign ready = !active;
  assign busy  = active;
  assign line  = shreg[0];
endmodule

// File: rtl/uart_lr_rx.sv
module uart_lr_rx
  import uart_lr_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              nine,
  input  logic              serial_in,
  output logic [WORD_W-1:0] data,
  output logic              valid,
  output logic              ferr
);
  localparam int unsigned CW   = $clog2(OVS);
  localparam int unsigned BW   = $clog2(WORD_W + 1);
  localparam int unsigned MIDC = OVS / 2 - 2;

  logic [1:0]        sync;
  logic              smp;
  logic              prev;
  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [BW-1:0]     last_bit;
  logic              long_frm;
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], serial_in};
  end
  assign smp = sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev     <= 1'b1;
      state    <= RX_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      last_bit <= '0;
      long_frm <= 1'b0;
      shreg    <= '0;
      data     <= '0;
      valid    <= 1'b0;
      ferr     <= 1'b0;
    end else begin
      valid <= 1'b0;
      ferr  <= 1'b0;
      if (tick) begin
        prev <= smp;
        unique case (state)
          RX_IDLE: begin
            if (prev && !smp) begin
              state    <= RX_START;
              cnt      <= '0;
              long_frm <= nine;
              last_bit <= nine ? BW'(WORD_W - 1) : BW'(WORD_W - 2);
            end
          end
          RX_START: begin
            if (cnt == CW'(MIDC)) begin
              cnt   <= '0;
              bitn  <= '0;
              state <= smp ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt == CW'(OVS - 1)) begin
              cnt   <= '0;
              shreg <= {smp, shreg[WORD_W-1:1]};
              bitn  <= bitn + 1'b1;
              if (bitn == last_bit) state <= RX_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt == CW'(OVS - 1)) begin
              cnt   <= '0;
              state <= RX_IDLE;
              valid <= 1'b1;
              ferr  <= !smp;
              data  <= long_frm ? shreg : {1'b0, shreg[WORD_W-1:1]};
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_lr_route.sv
module uart_lr_route
  import uart_lr_pkg::*;
(
  input  logic loop_en,
  input  logic src_sel,
  input  logic tx_line,
  input  logic tx_busy,
  input  logic pin_rd,
  input  logic rxd,
  output logic rx_in,
  output logic drive_en
);
  route_e rt;

  always_comb begin
    rt = pick_route(loop_en, src_sel);
    unique case (rt)
      RT_LOOP: begin
        rx_in    = tx_line;
        drive_en = 1'b1;
      end
      RT_WIRE: begin
        rx_in    = pin_rd;
        drive_en = tx_busy;
      end
      default: begin
        rx_in    = rxd;
        drive_en = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/uart_loop_xcvr.sv
module uart_loop_xcvr
  import uart_lr_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned OVS     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_loop,
  input  logic              cfg_src,
  input  logic              cfg_nine,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_ferr,
  output logic              txd_o,
  output logic              txd_oe,
  input  logic              txd_pin_i,
  input  logic              rxd_i
);
  logic tick;
  logic tx_line;
  logic tx_busy;
  logic rx_in;

  uart_lr_baud #(.CLK_DIV(CLK_DIV)) baud_i (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  uart_lr_tx #(.OVS(OVS)) tx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .nine(cfg_nine),
    .data(tx_data), .valid(tx_valid), .ready(tx_ready),
    .line(tx_line), .busy(tx_busy)
  );

  uart_lr_route route_i (
    .loop_en(cfg_loop), .src_sel(cfg_src), .tx_line(tx_line),
    .tx_busy(tx_busy), .pin_rd(txd_pin_i), .rxd(rxd_i),
    .rx_in(rx_in), .drive_en(txd_oe)
  );

  uart_lr_rx #(.OVS(OVS)) rx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .nine(cfg_nine),
    .serial_in(rx_in), .data(rx_data), .valid(rx_valid), .ferr(rx_ferr)
  );

  assign txd_o = tx_line;
endmodule

// File: rtl/uart_loop_xcvr_chk.sv
module uart_loop_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_loop,
  input logic       cfg_src,
  input logic       cfg_nine,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [8:0] rx_data,
  input logic       rx_valid,
  input logic       rx_ferr,
  input logic       txd_o,
  input logic       txd_oe
);
  assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd_o);

  assert_ready_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_short_bit8_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_nine) |-> !rx_data[8]);

  assert_ferr_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ferr |-> rx_valid);

  assert_oe_wire_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_loop && cfg_src && tx_ready) |-> !txd_oe);

  assert_oe_wire_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_loop && cfg_src && !tx_ready) |-> txd_oe);

  assert_oe_other_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_loop && cfg_src) |-> txd_oe);
endmodule

bind uart_loop_xcvr uart_loop_xcvr_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_loop(cfg_loop), .cfg_src(cfg_src),
  .cfg_nine(cfg_nine), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_data(rx_data), .rx_valid(rx_valid), .rx_ferr(rx_ferr),
  .txd_o(txd_o), .txd_oe(txd_oe)
);

// File: tb/uart_loop_xcvr_tb.sv
module uart_loop_xcvr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int OVS = 16;
  localparam int BIT_CLKS = DIV * OVS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_loop = 1'b0, cfg_src = 1'b0, cfg_nine = 1'b0;
  logic [8:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready;
  logic [8:0] rx_data;
  logic rx_valid, rx_ferr;
  logic txd_o, txd_oe;
  logic rxd_i = 1'b1;
  logic remote_drv = 1'b1;
  logic txd_pin;

  assign txd_pin = txd_oe ? txd_o : remote_drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_loop_xcvr #(.CLK_DIV(DIV), .OVS(OVS)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_loop(cfg_loop), .cfg_src(cfg_src),
    .cfg_nine(cfg_nine), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ferr(rx_ferr), .txd_o(txd_o), .txd_oe(txd_oe),
    .txd_pin_i(txd_pin), .rxd_i(rxd_i)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int rx_cnt = 0;
  logic [8:0] last_rx = '0;
  logic last_ferr = 1'b0;

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_cnt    <= rx_cnt + 1;
      last_rx   <= rx_data;
      last_ferr <= rx_ferr;
    end
  end

  function automatic logic [8:0] fmt(input logic [8:0] d, input logic nine);
    return nine ? d : {1'b0, d[7:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic send_word(input logic [8:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data  = d;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(!tx_ready, "R5 ready low after accept", 32'(tx_ready), 0);
  endtask

  task automatic grab_line(input logic nine, output logic [8:0] d, output logic st, output logic sb);
    d = '0;
    @(negedge txd_o);
    repeat (BIT_CLKS/2) @(negedge clk);
    sb = txd_o;
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      repeat (BIT_CLKS) @(negedge clk);
      d[i] = txd_o;
    end
    repeat (BIT_CLKS) @(negedge clk);
    st = txd_o;
  endtask

  task automatic set_line(input bit remote, input logic v);
    if (remote) remote_drv = v;
    else        rxd_i = v;
  endtask

  task automatic put_frame(input bit remote, input logic [8:0] d, input logic nine, input logic stopv);
    @(negedge clk);
    set_line(remote, 1'b0);
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      set_line(remote, d[i]);
      repeat (BIT_CLKS) @(negedge clk);
    end
    set_line(remote, stopv);
    repeat (BIT_CLKS) @(negedge clk);
    set_line(remote, 1'b1);
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic wait_tx_idle();
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // transmit one word and check the frame seen on txd_o
  task automatic tx_frame_check(input logic [8:0] d, input string req);
    logic [8:0] got; logic st, sb;
    fork
      send_word(d);
      grab_line(cfg_nine, got, st, sb);
    join
    chk(sb == 1'b0, req, 32'(sb), 0);
    chk(got == fmt(d, cfg_nine), req, 32'(got), 32'(fmt(d, cfg_nine)));
    chk(st == 1'b1, req, 32'(st), 1);
    wait_tx_idle();
    chk(txd_o == 1'b1, "R3 idle high", 32'(txd_o), 1);
  endtask

  task automatic rx_frame_check(input bit remote, input logic [8:0] d, input logic stopv, input string req);
    int c0;
    c0 = rx_cnt;
    put_frame(remote, d, cfg_nine, stopv);
    chk(rx_cnt == c0 + 1, req, 32'(rx_cnt - c0), 1);
    chk(last_rx == fmt(d, cfg_nine), req, 32'(last_rx), 32'(fmt(d, cfg_nine)));
    chk(last_ferr == !stopv, "R8 ferr", 32'(last_ferr), 32'(!stopv));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [8:0] d, d2, got;
    logic st, sb;
    int c0, off;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    chk(tx_ready == 1'b1, "R1 tx_ready", 32'(tx_ready), 1);
    chk(rx_valid == 1'b0, "R1 rx_valid", 32'(rx_valid), 0);
    chk(rx_ferr == 1'b0, "R1 rx_ferr", 32'(rx_ferr), 0);
    chk(txd_o == 1'b1, "R1 txd_o", 32'(txd_o), 1);
    chk(txd_oe == 1'b1, "R1 txd_oe", 32'(txd_oe), 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3 and R2: 8-bit two-pin transmit, own frame not heard
    foreach (d[i]) ;
    for (int n = 0; n < 5; n++) begin
      d = 9'($urandom());
      if (n == 0) d = 9'h100;
      if (n == 1) d = 9'h0FF;
      c0 = rx_cnt;
      tx_frame_check(d, "R3 8-bit frame");
      chk(rx_cnt == c0, "R2 no echo in two-pin", 32'(rx_cnt - c0), 0);
    end

    // R4: 9-bit transmit
    cfg_nine = 1'b1;
    tx_frame_check(9'h1A5, "R4 9-bit frame");
    tx_frame_check(9'h0FF, "R4 9-bit frame");
    tx_frame_check(9'($urandom()), "R4 9-bit frame");

    // R7 / R4: reception from rxd_i
    cfg_nine = 1'b0;
    rx_frame_check(0, 9'h1C3, 1'b1, "R7 rx 8-bit");
    rx_frame_check(0, 9'($urandom()), 1'b1, "R7 rx 8-bit");
    cfg_nine = 1'b1;
    rx_frame_check(0, 9'h155, 1'b1, "R4 rx 9-bit");
    rx_frame_check(0, 9'($urandom()), 1'b1, "R4 rx 9-bit");
    cfg_nine = 1'b0;

    // R8: framing error
    rx_frame_check(0, 9'h05A, 1'b0, "R8 bad stop");
    rx_frame_check(0, 9'h0A5, 1'b1, "R8 good stop after bad");

    // R6: glitch rejection
    c0 = rx_cnt;
    @(negedge clk);
    rxd_i = 1'b0;
    repeat (4*DIV) @(negedge clk);
    rxd_i = 1'b1;
    repeat (3*BIT_CLKS) @(negedge clk);
    chk(rx_cnt == c0, "R6 glitch ignored", 32'(rx_cnt - c0), 0);
    rx_frame_check(0, 9'h03C, 1'b1, "R6 frame after glitch");

    // R11: cfg_src ignored in two-pin mode
    cfg_src = 1'b1;
    chk(txd_oe == 1'b1, "R11 oe with src set", 32'(txd_oe), 1);
    rx_frame_check(0, 9'h0E7, 1'b1, "R11 rx with src set");
    c0 = rx_cnt;
    tx_frame_check(9'h081, "R11 tx with src set");
    chk(rx_cnt == c0, "R11 no echo", 32'(rx_cnt - c0), 0);
    cfg_src = 1'b0;

    // full duplex: both directions overlapping at random offsets
    for (int n = 0; n < 4; n++) begin
      d  = 9'($urandom());
      d2 = 9'($urandom());
      off = int'($urandom_range(0, BIT_CLKS*3));
      c0 = rx_cnt;
      fork
        send_word(d);
        grab_line(1'b0, got, st, sb);
        begin
          repeat (off) @(negedge clk);
          put_frame(0, d2, 1'b0, 1'b1);
        end
      join
      wait_tx_idle();
      chk(got == fmt(d, 1'b0) && st == 1'b1, "R3 duplex tx", 32'(got), 32'(fmt(d, 1'b0)));
      chk(rx_cnt == c0 + 1 && last_rx == fmt(d2, 1'b0), "R7 duplex rx", 32'(last_rx), 32'(fmt(d2, 1'b0)));
    end

    // R9: internal loopback, rxd_i held low
    cfg_loop = 1'b1;
    cfg_src  = 1'b0;
    rxd_i    = 1'b0;
    for (int n = 0; n < 4; n++) begin
      cfg_nine = n[0];
      d = 9'($urandom());
      c0 = rx_cnt;
      send_word(d);
      chk(txd_oe == 1'b1, "R9 oe in loopback", 32'(txd_oe), 1);
      wait_tx_idle();
      chk(rx_cnt == c0 + 1, "R9 echo count", 32'(rx_cnt - c0), 1);
      chk(last_rx == fmt(d, cfg_nine) && !last_ferr, "R9 echo data", 32'(last_rx), 32'(fmt(d, cfg_nine)));
    end

    // R10: single-wire
    cfg_src  = 1'b1;
    cfg_nine = 1'b0;
    repeat (2) @(negedge clk);
    chk(txd_oe == 1'b0, "R10 oe idle", 32'(txd_oe), 0);
    d = 9'h0C6;
    c0 = rx_cnt;
    send_word(d);
    chk(txd_oe == 1'b1, "R10 oe busy", 32'(txd_oe), 1);
    wait_tx_idle();
    chk(txd_oe == 1'b0, "R10 oe released", 32'(txd_oe), 0);
    chk(rx_cnt == c0 + 1 && last_rx == fmt(d, 1'b0), "R10 own echo", 32'(last_rx), 32'(fmt(d, 1'b0)));
    rxd_i = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
    rxd_i = 1'b0;
    rx_frame_check(1, 9'h139, 1'b1, "R10 remote rx on wire");
    cfg_nine = 1'b1;
    rx_frame_check(1, 9'($urandom()), 1'b1, "R10 remote rx 9-bit");
    c0 = rx_cnt;
    put_frame(0, 9'h0AA, 1'b1, 1'b1);
    chk(rx_cnt == c0, "R10 rxd_i ignored", 32'(rx_cnt - c0), 0);

    finish_run();
  end
endmodule